// File: doc/BRIEF.md
# Register Remap Unit

This block turns a 5-bit architectural register number into a 6-bit physical register number, so that operands can reach a register space twice the size of the architectural one. It keeps two programmable 32-entry tables: one for integer registers and one for floating-point registers. A select bit on each request picks the table. Every entry has four fields: a redirect enable, a vector flag, an element-width code and a 6-bit target index.

The redirect enable and the vector flag are separate controls. An entry that is enabled but not vector moves a scalar register into the wider space. An entry that is enabled and vector adds the operand's loop offset to the target and hands back the offset plus one, ready for the next element. A nonzero element-width code is not supported and raises an exception flag. A target plus offset that goes past the top of the physical space wraps and raises an overflow flag.

Lookups are registered, so a response appears one cycle after its request. Table writes land on the same clock edge. A separate combinational query port reports, from the current table contents, whether a register is vectorised. The instruction decoder and the register file itself are outside this block.

Top module: `vreg_remap`

## Requirements
- R1: After reset every entry of both tables is disabled: `rsp_valid` is 0, `qry_vec` is 0 and every lookup returns its own register number.
- R2: A lookup whose selected entry has its redirect enable at 0 returns the architectural number zero-extended to 6 bits. It also returns `rsp_off` equal to `req_off`, with `rsp_vec` and `rsp_ovf` at 0.
- R3: A lookup whose selected entry is enabled with the vector flag at 0 returns the stored target index. It returns `rsp_off` equal to `req_off`, with `rsp_vec` and `rsp_ovf` at 0.
- R4: A lookup whose selected entry is enabled with the vector flag at 1 and `req_off_vld` at 1 returns target plus `req_off`, taken modulo 64. It returns `rsp_off` = (`req_off` + 1) modulo 64 and `rsp_vec` = 1.
- R5: For such a vector entry with `req_off_vld` at 0, the offset is taken as 0. The lookup returns the target itself and `rsp_off` = 1.
- R6: `rsp_ovf` is 1 exactly when a vector lookup's target plus effective offset exceeds 63. The returned register is then the sum truncated to 6 bits.
- R7: `rsp_exc` is 1 exactly when the selected entry's 2-bit element-width code is nonzero, whether or not the entry is enabled.
- R8: `req_fp` = 0 selects the integer table and `req_fp` = 1 selects the floating-point table. A write to one table, chosen by `wr_fp`, leaves every entry of the other unchanged.
- R9: `qry_vec` is 1 in the same cycle exactly when the entry chosen by `qry_fp`/`qry_reg` is both enabled and vector, reflecting all writes completed on earlier edges.
- R10: A lookup made in the same cycle as a write to the same entry returns the entry's contents from before that write.
- R11: `rsp_valid` is 1 in the cycle after `req_valid` was 1, and 0 otherwise. The response fields belong to that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Table write strobe |
| wr_fp | input | 1 | Write target table: 0 integer, 1 floating-point |
| wr_idx | input | 5 | Entry written (architectural register) |
| wr_act | input | 1 | Redirect enable written |
| wr_vec | input | 1 | Vector flag written |
| wr_ew | input | 2 | Element-width code written (only 0 supported) |
| wr_tgt | input | 6 | Target physical index written |
| req_valid | input | 1 | Lookup request strobe |
| req_fp | input | 1 | Lookup table select: 0 integer, 1 floating-point |
| req_reg | input | 5 | Architectural register looked up |
| req_off_vld | input | 1 | Loop offset applies when 1; offset taken as 0 when 0 |
| req_off | input | 6 | Current loop offset of the operand |
| qry_fp | input | 1 | Query table select |
| qry_reg | input | 5 | Register queried |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_phys | output | 6 | Physical register number |
| rsp_off | output | 6 | Offset to use for the next lookup |
| rsp_vec | output | 1 | Entry was enabled and vector |
| rsp_exc | output | 1 | Unsupported element-width code |
| rsp_ovf | output | 1 | Target plus offset exceeded 63 |
| qry_vec | output | 1 | Queried register is vectorised |

## Verification
A corrupted table entry shows at the ports through one of two paths. A query of that entry gives a wrong `qry_vec` in the very next cycle after the bad write edge. A lookup of it gives a wrong `rsp_phys`, `rsp_off` or `rsp_exc` one cycle after the request. A stuck or misrouted table select shows as integer and floating-point lookups of the same register returning each other's mapping. An offset adder fault shows as `rsp_phys` or `rsp_off` off by the offset, or as a wrong overflow flag near the top of the space. A behavioural model of both tables is compared against every response and every query on each clock, so a divergence is reported within one cycle of the request that exposes it.

// File: rtl/vrm_pkg.sv
package vrm_pkg;
    localparam int NUM_CLASSES = 2;

    typedef enum logic [1:0] {
        KIND_IDENT  = 2'd0,
        KIND_SCALAR = 2'd1,
        KIND_VECTOR = 2'd2
    } map_kind_e;
endpackage

// File: rtl/vrm_table.sv
module vrm_table #(
    parameter int ARCH_W   = 5,
    parameter int PHYS_W   = 6,
    parameter int EW_W     = 2,
    parameter int CLASS_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_cls,
    input  logic [ARCH_W-1:0] wr_idx,
    input  logic              wr_act,
    input  logic              wr_vec,
    input  logic [EW_W-1:0]   wr_ew,
    input  logic [PHYS_W-1:0] wr_tgt,
    input  logic [ARCH_W-1:0] a_idx,
    output logic              a_act,
    output logic              a_vec,
    output logic [EW_W-1:0]   a_ew,
    output logic [PHYS_W-1:0] a_tgt,
    input  logic [ARCH_W-1:0] b_idx,
    output logic              b_act,
    output logic              b_vec
);
    localparam int DEPTH = 1 << ARCH_W;

    typedef struct packed {
        logic [DEPTH-1:0]             act;
        logic [DEPTH-1:0]             vec;
        logic [DEPTH-1:0][EW_W-1:0]   ew;
        logic [DEPTH-1:0][PHYS_W-1:0] tgt;
    } tbl_t;

    tbl_t tbl_d, tbl_q;
    logic sel_me;

    assign sel_me = (wr_cls == CLASS_ID[0]);

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en && sel_me) begin
            tbl_d.act[wr_idx] = wr_act;
            tbl_d.vec[wr_idx] = wr_vec;
            tbl_d.ew[wr_idx]  = wr_ew;
            tbl_d.tgt[wr_idx] = wr_tgt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign a_act = tbl_q.act[a_idx];
    assign a_vec = tbl_q.vec[a_idx];
    assign a_ew  = tbl_q.ew[a_idx];
    assign a_tgt = tbl_q.tgt[a_idx];
    assign b_act = tbl_q.act[b_idx];
    assign b_vec = tbl_q.vec[b_idx];
endmodule

// File: rtl/vrm_xlate.sv
module vrm_xlate
    import vrm_pkg::*;
#(
    parameter int ARCH_W = 5,
    parameter int PHYS_W = 6,
    parameter int EW_W   = 2
) (
    input  logic              ent_act,
    input  logic              ent_vec,
    input  logic [EW_W-1:0]   ent_ew,
    input  logic [PHYS_W-1:0] ent_tgt,
    input  logic [ARCH_W-1:0] arch,
    input  logic              off_vld,
    input  logic [PHYS_W-1:0] off,
    output map_kind_e         kind,
    output logic [PHYS_W-1:0] phys,
    output logic [PHYS_W-1:0] off_nxt,
    output logic              ovf,
    output logic              exc
);
    logic [PHYS_W-1:0] off_eff;
    logic [PHYS_W:0]   sum;

    always_comb begin
        off_eff = off_vld ? off : '0;
        sum     = {1'b0, ent_tgt} + {1'b0, off_eff};
        exc     = (ent_ew != '0);
        if (!ent_act) begin
            kind = KIND_IDENT;
        end else if (!ent_vec) begin
            kind = KIND_SCALAR;
        end else begin
            kind = KIND_VECTOR;
        end
        unique case (kind)
            KIND_SCALAR: begin
                phys    = ent_tgt;
                off_nxt = off;
                ovf     = 1'b0;
            end
            KIND_VECTOR: begin
                phys    = sum[PHYS_W-1:0];
                off_nxt = off_eff + PHYS_W'(1);
                ovf     = sum[PHYS_W];
            end
            default: begin
                phys    = {{(PHYS_W-ARCH_W){1'b0}}, arch};
                off_nxt = off;
                ovf     = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/vreg_remap.sv
module vreg_remap
    import vrm_pkg::*;
#(
    parameter int ARCH_W = 5,
    parameter int PHYS_W = 6,
    parameter int EW_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_fp,
    input  logic [ARCH_W-1:0] wr_idx,
    input  logic              wr_act,
    input  logic              wr_vec,
    input  logic [EW_W-1:0]   wr_ew,
    input  logic [PHYS_W-1:0] wr_tgt,
    input  logic              req_valid,
    input  logic              req_fp,
    input  logic [ARCH_W-1:0] req_reg,
    input  logic              req_off_vld,
    input  logic [PHYS_W-1:0] req_off,
    input  logic              qry_fp,
    input  logic [ARCH_W-1:0] qry_reg,
    output logic              rsp_valid,
    output logic [PHYS_W-1:0] rsp_phys,
    output logic [PHYS_W-1:0] rsp_off,
    output logic              rsp_vec,
    output logic              rsp_exc,
    output logic              rsp_ovf,
    output logic              qry_vec
);
    typedef struct packed {
        logic              valid;
        logic [PHYS_W-1:0] phys;
        logic [PHYS_W-1:0] off;
        logic              vec;
        logic              exc;
        logic              ovf;
    } rsp_t;

    logic [NUM_CLASSES-1:0]             a_act, a_vec, b_act, b_vec;
    logic [NUM_CLASSES-1:0][EW_W-1:0]   a_ew;
    logic [NUM_CLASSES-1:0][PHYS_W-1:0] a_tgt;

    for (genvar g = 0; g < NUM_CLASSES; g++) begin : g_cls
        vrm_table #(
            .ARCH_W  (ARCH_W),
            .PHYS_W  (PHYS_W),
            .EW_W    (EW_W),
            .CLASS_ID(g)
        ) u_tbl (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr_en),
            .wr_cls(wr_fp),
            .wr_idx(wr_idx),
            .wr_act(wr_act),
            .wr_vec(wr_vec),
            .wr_ew (wr_ew),
            .wr_tgt(wr_tgt),
            .a_idx (req_reg),
            .a_act (a_act[g]),
            .a_vec (a_vec[g]),
            .a_ew  (a_ew[g]),
            .a_tgt (a_tgt[g]),
            .b_idx (qry_reg),
            .b_act (b_act[g]),
            .b_vec (b_vec[g])
        );
    end

    map_kind_e         x_kind;
    logic [PHYS_W-1:0] x_phys, x_off;
    logic              x_ovf, x_exc;

    vrm_xlate #(
        .ARCH_W(ARCH_W),
        .PHYS_W(PHYS_W),
        .EW_W  (EW_W)
    ) u_xlate (
        .ent_act(a_act[req_fp]),
        .ent_vec(a_vec[req_fp]),
        .ent_ew (a_ew[req_fp]),
        .ent_tgt(a_tgt[req_fp]),
        .arch   (req_reg),
        .off_vld(req_off_vld),
        .off    (req_off),
        .kind   (x_kind),
        .phys   (x_phys),
        .off_nxt(x_off),
        .ovf    (x_ovf),
        .exc    (x_exc)
    );

    rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            rsp_d.phys = x_phys;
            rsp_d.off  = x_off;
            rsp_d.vec  = (x_kind == KIND_VECTOR);
            rsp_d.exc  = x_exc;
            rsp_d.ovf  = x_ovf;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_phys  = rsp_q.phys;
    assign rsp_off   = rsp_q.off;
    assign rsp_vec   = rsp_q.vec;
    assign rsp_exc   = rsp_q.exc;
    assign rsp_ovf   = rsp_q.ovf;
    assign qry_vec   = b_act[qry_fp] & b_vec[qry_fp];
endmodule

// File: rtl/vrm_chk.sv
module vrm_chk #(
    parameter int PHYS_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_off_vld,
    input logic [PHYS_W-1:0] req_off,
    input logic              rsp_valid,
    input logic [PHYS_W-1:0] rsp_off,
    input logic              rsp_vec,
    input logic              rsp_ovf
);
    // R11
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R11
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R6
    ovf_only_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ovf) |-> rsp_vec);

    // R2
    scalar_off_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_vec || rsp_off == $past(req_off)));

    // R4
    vector_off_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!rsp_vec ||
            rsp_off == PHYS_W'(($past(req_off_vld) ? $past(req_off) : '0) + 1)));
endmodule

bind vreg_remap vrm_chk #(.PHYS_W(PHYS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_off_vld(req_off_vld),
    .req_off    (req_off),
    .rsp_valid  (rsp_valid),
    .rsp_off    (rsp_off),
    .rsp_vec    (rsp_vec),
    .rsp_ovf    (rsp_ovf)
);

// File: tb/sim_vreg_remap.sv
module sim_vreg_remap;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 0, wr_fp = 0, wr_act = 0, wr_vec = 0;
    logic [4:0] wr_idx = '0;
    logic [1:0] wr_ew = '0;
    logic [5:0] wr_tgt = '0;
    logic       req_valid = 0, req_fp = 0, req_off_vld = 0;
    logic [4:0] req_reg = '0;
    logic [5:0] req_off = '0;
    logic       qry_fp = 0;
    logic [4:0] qry_reg = '0;
    logic       rsp_valid, rsp_vec, rsp_exc, rsp_ovf, qry_vec;
    logic [5:0] rsp_phys, rsp_off;

    always #(CLK_PERIOD/2) clk = ~clk;

    vreg_remap u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_fp(wr_fp), .wr_idx(wr_idx), .wr_act(wr_act),
        .wr_vec(wr_vec), .wr_ew(wr_ew), .wr_tgt(wr_tgt),
        .req_valid(req_valid), .req_fp(req_fp), .req_reg(req_reg),
        .req_off_vld(req_off_vld), .req_off(req_off),
        .qry_fp(qry_fp), .qry_reg(qry_reg),
        .rsp_valid(rsp_valid), .rsp_phys(rsp_phys), .rsp_off(rsp_off),
        .rsp_vec(rsp_vec), .rsp_exc(rsp_exc), .rsp_ovf(rsp_ovf),
        .qry_vec(qry_vec)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit any_write = 0;

    // behavioural model of both tables
    bit m_act [2][32];
    bit m_vec [2][32];
    int m_ew  [2][32];
    int m_tgt [2][32];

    bit    e_valid = 0, e_vec = 0, e_exc = 0, e_ovf = 0;
    int    e_phys = 0, e_off = 0;
    string e_tag = "R1";

    task automatic check(input int act, input int exp, input string tag, input string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++)
                for (int r = 0; r < 32; r++) begin
                    m_act[c][r] = 0; m_vec[c][r] = 0; m_ew[c][r] = 0; m_tgt[c][r] = 0;
                end
            e_valid = 0;
            any_write = 0;
        end else begin
            e_valid = req_valid;
            if (req_valid) begin
                int c, r, eo, s;
                c = int'(req_fp); r = int'(req_reg);
                e_exc = (m_ew[c][r] != 0);
                e_ovf = 0; e_vec = 0;
                if (!m_act[c][r]) begin
                    e_phys = r; e_off = int'(req_off); e_tag = any_write ? "R2" : "R1";
                end else if (!m_vec[c][r]) begin
                    e_phys = m_tgt[c][r]; e_off = int'(req_off); e_tag = "R3";
                end else begin
                    eo = req_off_vld ? int'(req_off) : 0;
                    s = m_tgt[c][r] + eo;
                    e_phys = s % 64; e_ovf = (s > 63); e_vec = 1;
                    e_off = (eo + 1) % 64;
                    e_tag = req_off_vld ? "R4" : "R5";
                end
                if (req_fp) e_tag = {e_tag, "/R8"};
                if (wr_en && wr_fp == req_fp && wr_idx == req_reg) e_tag = {e_tag, "/R10"};
            end
            if (wr_en) begin
                any_write = 1;
                m_act[wr_fp][wr_idx] = wr_act;
                m_vec[wr_fp][wr_idx] = wr_vec;
                m_ew[wr_fp][wr_idx]  = int'(wr_ew);
                m_tgt[wr_fp][wr_idx] = int'(wr_tgt);
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check(int'(rsp_valid), int'(e_valid), "R11", "rsp_valid");
            if (e_valid) begin
                check(int'(rsp_phys), e_phys, e_tag, "rsp_phys");
                check(int'(rsp_off), e_off, e_tag, "rsp_off");
                check(int'(rsp_vec), int'(e_vec), e_tag, "rsp_vec");
                check(int'(rsp_exc), int'(e_exc), "R7", "rsp_exc");
                check(int'(rsp_ovf), int'(e_ovf), "R6", "rsp_ovf");
            end
            check(int'(qry_vec), int'(m_act[qry_fp][qry_reg] && m_vec[qry_fp][qry_reg]),
                  "R9", "qry_vec");
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input bit fp, input int idx, input bit act, input bit vec,
                      input int ew, input int tgt);
        wr_en = 1; wr_fp = fp; wr_idx = 5'(idx); wr_act = act; wr_vec = vec;
        wr_ew = 2'(ew); wr_tgt = 6'(tgt);
    endtask

    task automatic rq(input bit fp, input int r, input bit vld, input int off);
        req_valid = 1; req_fp = fp; req_reg = 5'(r); req_off_vld = vld; req_off = 6'(off);
        qry_fp = fp; qry_reg = 5'(r);
    endtask

    task automatic idle();
        wr_en = 0; req_valid = 0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1;
        step();
        // R1: reset state at the ports before any traffic
        check(int'(rsp_valid), 0, "R1", "rsp_valid after reset");
        check(int'(qry_vec), 0, "R1", "qry_vec after reset");
        // R1/R2: identity in both tables
        for (int r = 0; r < 32; r++) begin
            rq(0, r, r[0], r); step();
            rq(1, r, 1, 63 - r); step();
        end
        idle(); step();
        // R3 and R8: scalar redirect in the integer table only
        wr(0, 5, 1, 0, 0, 35); step(); idle();
        rq(0, 5, 1, 7); step();
        rq(1, 5, 1, 7); step();
        // R4/R5: vector entry walking offsets
        wr(0, 6, 1, 1, 0, 40); step(); idle();
        rq(0, 6, 0, 9); step();
        for (int k = 0; k < 4; k++) begin rq(0, 6, 1, k); step(); end
        // R6: overflow near the top of the space
        wr(1, 7, 1, 1, 0, 60); step(); idle();
        rq(1, 7, 1, 2); step();
        rq(1, 7, 1, 3); step();
        rq(1, 7, 1, 4); step();
        rq(1, 7, 1, 63); step();
        // R7: element width nonzero, inactive and active
        wr(0, 9, 0, 0, 1, 12); step(); idle();
        rq(0, 9, 0, 0); step();
        wr(0, 9, 1, 0, 3, 12); step(); idle();
        rq(0, 9, 0, 0); step();
        // R10: write and lookup of the same entry in one cycle
        wr(0, 10, 1, 1, 0, 20); rq(0, 10, 1, 1); step();
        idle(); rq(0, 10, 1, 1); step();
        wr(1, 10, 1, 0, 0, 50); rq(1, 10, 1, 1); step();
        idle(); rq(1, 10, 1, 1); step();
        idle(); step();
        // mixed random traffic
        for (int i = 0; i < 600; i++) begin
            wr_en = ($urandom_range(0, 3) == 0);
            wr_fp = 1'($urandom); wr_idx = 5'($urandom); wr_act = 1'($urandom);
            wr_vec = 1'($urandom); wr_ew = ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'd0;
            wr_tgt = 6'($urandom);
            req_valid = ($urandom_range(0, 3) != 0);
            req_fp = 1'($urandom); req_reg = 5'($urandom);
            req_off_vld = 1'($urandom); req_off = 6'($urandom);
            qry_fp = 1'($urandom); qry_reg = 5'($urandom);
            step();
        end
        idle(); step(); step();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule